// File: doc/BRIEF.md
# Cipher key register file

This block stores the secret key used by a symmetric cipher engine. Software loads the key as 64-bit words over a simple register write port and programs its length (16, 24 or 32 bytes) in a separate size register. The block drives the whole key, together with a per-byte mask of the valid length, straight to the engine. It raises a key-valid output once every word that the programmed length needs has been loaded.

The block protects the key while a message is in flight. A key write that arrives while the engine reports busy is dropped, and it sets a sticky context error. Software clears that error with a write-one-to-clear or with a reinit pulse. When decrypt mode is selected, the key words can be read back so that software can save a context. If a saved key is written back and the restore bit is set, the block tells the engine that the key is already expanded, so expansion is skipped.

Top module: `ckey_bank`

## Requirements
- R1: Writing a word to address 4+k (k = 0..3) stores it as key word k. Word 0, at address 4, holds key bytes 0..7 and drives `key_o[63:0]`. Word k drives `key_o[64k+63:64k]`.
- R2: Bit i of `key_mask_o` is 1 exactly when i is below the programmed size in bytes. Key bytes at or beyond the size read as zero on `key_o`. A write to word k with k >= size/8 is ignored.
- R3: Reset and `reinit_i` clear every key word, the written record, the context error and the mode bits, and they return the size to 16. `reinit_i` wins over a write made in the same cycle.
- R4: A key-word write made while `busy_i` is high leaves the stored key unchanged and sets `ctx_err_o` on the next cycle.
- R5: Writing the size register (address 1) stores the value 16, 24 or 32 as written. Any other value stores 16 and sets `ctx_err_o`.
- R6: `ctx_err_o` stays high until address 2 is written with bit 0 = 1, or until reinit. A write to address 2 with bit 0 = 0 leaves it unchanged.
- R7: `key_valid_o` is high exactly when every word index below size/8 has been written since the last reset or reinit.
- R8: A read with `rd_en_i` returns its data on `rd_data_o` one cycle later, from the state before that cycle's write. The fields are:
  - address 0 returns the mode bits, with bit 1 = decrypt and bit 0 = restore;
  - address 1 returns the size;
  - address 2 returns key-valid in bit 1 and the context error in bit 0;
  - addresses 4..7 return the key word as masked on `key_o`, but only while the decrypt bit is set, and 0 otherwise;
  - address 3 returns 0.
- R9: Writing address 0 loads the mode bits from data bits 1:0. `restore_key_o` is high exactly when both mode bits are set and `key_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reinit_i | input | 1 | Synchronous clear of key, mode, size and error |
| busy_i | input | 1 | Engine is processing a message |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 64 | Read data, one cycle after the strobe |
| key_o | output | 256 | Key to the engine, masked to the size |
| key_mask_o | output | 32 | Per-byte valid mask |
| key_valid_o | output | 1 | All needed words are loaded |
| ctx_err_o | output | 1 | Sticky context error |
| restore_key_o | output | 1 | Key is pre-expanded; skip expansion |

## Verification
Two functions can land in the same cycle. The first case is a `reinit_i` pulse together with a key-word write, or together with an illegal size write; the bench provokes it deliberately and expects the clear to win, with no error and an all-zero key. The second case is a read of a register in the same cycle that a write changes it; the bench expects the read to return the value from before the write. A randomized phase then mixes busy, reinit, reads and writes on every cycle, and a behavioural model is compared against all outputs on every clock.

// File: rtl/ckey_pkg.sv
package ckey_pkg;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_SIZE = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } ctl_reg_e;

  // Number of key words covered by a key of size_bytes.
  function automatic int words_for(int size_bytes, int word_w);
    return (size_bytes * 8) / word_w;
  endfunction

  // Smallest legal key, in bytes: two words.
  function automatic int min_bytes(int word_w);
    return 2 * (word_w / 8);
  endfunction

  // A legal size is a whole number of words, from two words up to n_words.
  function automatic logic size_legal(logic [63:0] v, int word_w, int n_words);
    logic ok;
    ok = 1'b0;
    for (int w = 2; w <= n_words; w++) begin
      if (v == 64'(w * (word_w / 8))) ok = 1'b1;
    end
    return ok;
  endfunction

endpackage

// File: rtl/ckey_ctrl.sv
module ckey_ctrl
  import ckey_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 64,
  parameter int IDX_W   = 2,
  parameter int ADDR_W  = 3,
  parameter int SZ_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit_i,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [1:0]        mode_q,
  output logic [SZ_W-1:0]   size_q,
  output logic              err_q,
  output logic              key_wr_ok,
  output logic [IDX_W-1:0]  key_idx,
  output logic [IDX_W:0]    words_need,
  output logic              busy_wr_evt,
  output logic              bad_size_evt,
  output logic              clr_evt
);

  localparam logic [SZ_W-1:0] SIZE_MIN = SZ_W'(min_bytes(WORD_W));

  logic     is_key, ctl_sel, in_range, size_wr, size_ok, mode_wr;
  ctl_reg_e ctl_reg;

  assign is_key     = wr_en_i & wr_addr_i[ADDR_W-1];
  assign ctl_sel    = wr_en_i & ~wr_addr_i[ADDR_W-1];
  assign ctl_reg    = ctl_reg_e'(wr_addr_i[1:0]);
  assign key_idx    = wr_addr_i[IDX_W-1:0];
  assign words_need = (IDX_W+1)'(words_for(int'(size_q), WORD_W));
  assign in_range   = {1'b0, key_idx} < words_need;

  assign busy_wr_evt  = is_key & busy_i & ~reinit_i;
  assign key_wr_ok    = is_key & ~busy_i & in_range & ~reinit_i;
  assign mode_wr      = ctl_sel & (ctl_reg == REG_MODE) & ~reinit_i;
  assign size_wr      = ctl_sel & (ctl_reg == REG_SIZE) & ~reinit_i;
  assign size_ok      = size_legal(64'(wr_data_i), WORD_W, N_WORDS);
  assign bad_size_evt = size_wr & ~size_ok;
  assign clr_evt      = ctl_sel & (ctl_reg == REG_STAT) & wr_data_i[0] & ~reinit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      size_q <= SIZE_MIN;
      err_q  <= 1'b0;
    end else if (reinit_i) begin
      mode_q <= '0;
      size_q <= SIZE_MIN;
      err_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= wr_data_i[1:0];
      if (size_wr) size_q <= size_ok ? wr_data_i[SZ_W-1:0] : SIZE_MIN;
      if (busy_wr_evt || bad_size_evt) err_q <= 1'b1;
      else if (clr_evt)                err_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ckey_store.sv
module ckey_store #(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 64,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      wr_ok_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [WORD_W-1:0]         wr_data_i,
  input  logic [IDX_W:0]            words_need_i,
  output logic [N_WORDS*WORD_W-1:0] store_o,
  output logic [N_WORDS-1:0]        written_o,
  output logic                      key_valid_o
);

  logic [N_WORDS-1:0] need;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        wr_q   <= 1'b0;
      end else if (clr_i) begin
        word_q <= '0;
        wr_q   <= 1'b0;
      end else if (wr_ok_i && (wr_idx_i == IDX_W'(g))) begin
        word_q <= wr_data_i;
        wr_q   <= 1'b1;
      end
    end

    assign store_o[g*WORD_W +: WORD_W] = word_q;
    assign written_o[g]                = wr_q;
    assign need[g]                     = (IDX_W+1)'(g) < words_need_i;
  end

  assign key_valid_o = &(written_o | ~need);

endmodule

// File: rtl/ckey_rdport.sv
module ckey_rdport #(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 64,
  parameter int IDX_W   = 2,
  parameter int ADDR_W  = 3,
  parameter int SZ_W    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  input  logic [1:0]                mode_i,
  input  logic [SZ_W-1:0]           size_i,
  input  logic                      err_i,
  input  logic                      valid_i,
  input  logic [N_WORDS*WORD_W-1:0] key_i,
  output logic [WORD_W-1:0]         rd_data_o
);

  logic [WORD_W-1:0] words [N_WORDS];
  logic [WORD_W-1:0] rd_next;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_unpack
    assign words[g] = key_i[g*WORD_W +: WORD_W];
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr_i[ADDR_W-1]) begin
      if (mode_i[1]) rd_next = words[rd_addr_i[IDX_W-1:0]];
    end else begin
      case (rd_addr_i[1:0])
        2'd0:    rd_next = WORD_W'(mode_i);
        2'd1:    rd_next = WORD_W'(size_i);
        2'd2:    rd_next = WORD_W'({valid_i, err_i});
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_next;
  end

endmodule

// File: rtl/ckey_bank.sv
module ckey_bank
  import ckey_pkg::*;
#(
  parameter  int N_WORDS = 4,
  parameter  int WORD_W  = 64,
  localparam int IDX_W   = $clog2(N_WORDS),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int KEY_W   = N_WORDS * WORD_W,
  localparam int KBYTES  = KEY_W / 8,
  localparam int SZ_W    = $clog2(KBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit_i,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [KEY_W-1:0]  key_o,
  output logic [KBYTES-1:0] key_mask_o,
  output logic              key_valid_o,
  output logic              ctx_err_o,
  output logic              restore_key_o
);

  logic [1:0]         mode_q;
  logic [SZ_W-1:0]    size_q;
  logic               key_wr_ok, busy_wr_evt, bad_size_evt, clr_evt;
  logic [IDX_W-1:0]   key_idx;
  logic [IDX_W:0]     words_need;
  logic [KEY_W-1:0]   store_flat;
  logic [N_WORDS-1:0] written;

  ckey_ctrl #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W),
              .ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reinit_i(reinit_i), .busy_i(busy_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .mode_q(mode_q), .size_q(size_q), .err_q(ctx_err_o),
    .key_wr_ok(key_wr_ok), .key_idx(key_idx), .words_need(words_need),
    .busy_wr_evt(busy_wr_evt), .bad_size_evt(bad_size_evt), .clr_evt(clr_evt)
  );

  ckey_store #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_i(reinit_i), .wr_ok_i(key_wr_ok),
    .wr_idx_i(key_idx), .wr_data_i(wr_data_i), .words_need_i(words_need),
    .store_o(store_flat), .written_o(written), .key_valid_o(key_valid_o)
  );

  for (genvar b = 0; b < KBYTES; b++) begin : g_mask
    assign key_mask_o[b]      = SZ_W'(b) < size_q;
    assign key_o[b*8 +: 8]    = key_mask_o[b] ? store_flat[b*8 +: 8] : 8'h00;
  end

  assign restore_key_o = &mode_q & key_valid_o;

  ckey_rdport #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W),
                .ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .mode_i(mode_q), .size_i(size_q), .err_i(ctx_err_o), .valid_i(key_valid_o),
    .key_i(key_o), .rd_data_o(rd_data_o)
  );

endmodule

// File: rtl/ckey_bank_chk.sv
module ckey_bank_chk #(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 64,
  parameter int KEY_W   = 256,
  parameter int KBYTES  = 32,
  parameter int SZ_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reinit_i,
  input logic              busy_i,
  input logic [KEY_W-1:0]  store_flat,
  input logic [KBYTES-1:0] key_mask_o,
  input logic [SZ_W-1:0]   size_q,
  input logic              busy_wr_evt,
  input logic              bad_size_evt,
  input logic              clr_evt,
  input logic              key_valid_o,
  input logic              ctx_err_o,
  input logic              restore_key_o
);

  AST_KEY_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !reinit_i) |=> $stable(store_flat)); // R4
  AST_BUSY_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_wr_evt |=> ctx_err_o); // R4
  AST_REINIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_i |=> (store_flat == '0 && !ctx_err_o && !key_valid_o)); // R3
  AST_MASK_MATCHES_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(key_mask_o) == int'(size_q)); // R2
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ckey_pkg::size_legal(64'(size_q), WORD_W, N_WORDS)); // R5
  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_size_evt |=> ctx_err_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_err_o && !reinit_i && !clr_evt) |=> ctx_err_o); // R6
  AST_RESTORE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    restore_key_o |-> key_valid_o); // R9

endmodule

bind ckey_bank ckey_bank_chk #(
  .N_WORDS(N_WORDS), .WORD_W(WORD_W), .KEY_W(KEY_W), .KBYTES(KBYTES), .SZ_W(SZ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reinit_i(reinit_i), .busy_i(busy_i),
  .store_flat(store_flat), .key_mask_o(key_mask_o), .size_q(size_q),
  .busy_wr_evt(busy_wr_evt), .bad_size_evt(bad_size_evt), .clr_evt(clr_evt),
  .key_valid_o(key_valid_o), .ctx_err_o(ctx_err_o), .restore_key_o(restore_key_o)
);

// File: tb/sim_ckey_bank.sv
`timescale 1ns/1ps
module sim_ckey_bank;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reinit_i = 1'b0, busy_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]   wr_addr_i = '0, rd_addr_i = '0;
  logic [63:0]  wr_data_i = '0;
  logic [63:0]  rd_data_o;
  logic [255:0] key_o;
  logic [31:0]  key_mask_o;
  logic         key_valid_o, ctx_err_o, restore_key_o;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // behavioural model state
  logic [63:0] m_key [4];
  bit          m_wr  [4];
  int          m_size;
  bit          m_err;
  logic [1:0]  m_mode;
  logic [63:0] m_rd;

  always #2.5 clk = ~clk;

  ckey_bank u0 (.*);

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin m_key[i] = '0; m_wr[i] = 0; end
    m_size = 16; m_err = 0; m_mode = 2'b00;
  endtask

  function automatic logic [63:0] model_word(int i);
    return (i < m_size / 8) ? m_key[i] : 64'h0;
  endfunction

  function automatic bit model_valid();
    bit v = 1;
    for (int i = 0; i < m_size / 8; i++) if (!m_wr[i]) v = 0;
    return v;
  endfunction

  task automatic model_step();
    logic [63:0] r;
    int idx;
    if (rd_en_i) begin
      r = '0;
      if (rd_addr_i[2]) begin
        if (m_mode[1]) r = model_word(int'(rd_addr_i[1:0]));
      end else if (rd_addr_i[1:0] == 2'd0) r = 64'(m_mode);
      else if (rd_addr_i[1:0] == 2'd1) r = 64'(m_size);
      else if (rd_addr_i[1:0] == 2'd2) r = {62'd0, model_valid(), m_err};
      m_rd = r;
    end
    if (reinit_i) model_clear();
    else if (wr_en_i) begin
      if (wr_addr_i[2]) begin
        idx = int'(wr_addr_i[1:0]);
        if (busy_i) m_err = 1;
        else if (idx < m_size / 8) begin m_key[idx] = wr_data_i; m_wr[idx] = 1; end
      end else if (wr_addr_i[1:0] == 2'd0) m_mode = wr_data_i[1:0];
      else if (wr_addr_i[1:0] == 2'd1) begin
        if (wr_data_i == 64'd16 || wr_data_i == 64'd24 || wr_data_i == 64'd32)
          m_size = int'(wr_data_i);
        else begin m_size = 16; m_err = 1; end
      end else if (wr_addr_i[1:0] == 2'd2 && wr_data_i[0]) m_err = 0;
    end
  endtask

  task automatic compare();
    logic [255:0] ek;
    logic [31:0]  em;
    for (int i = 0; i < 4; i++) ek[i*64 +: 64] = model_word(i);
    for (int b = 0; b < 32; b++) em[b] = (b < m_size);
    chk(key_o == ek, "R1 key_o", key_o, ek);
    chk(key_mask_o == em, "R2 key_mask_o", 256'(key_mask_o), 256'(em));
    chk(key_valid_o == model_valid(), "R7 key_valid_o", 256'(key_valid_o), 256'(model_valid()));
    chk(ctx_err_o == m_err, "R6 ctx_err_o", 256'(ctx_err_o), 256'(m_err));
    chk(restore_key_o == ((m_mode == 2'b11) && model_valid()), "R9 restore_key_o",
        256'(restore_key_o), 256'((m_mode == 2'b11) && model_valid()));
    chk(rd_data_o == m_rd, "R8 rd_data_o", 256'(rd_data_o), 256'(m_rd));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    wr_en_i = 0; rd_en_i = 0; reinit_i = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [63:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d; cycle();
  endtask

  task automatic rd(logic [2:0] a);
    rd_en_i = 1; rd_addr_i = a; cycle();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    model_clear(); m_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare();
    // R3: reset state
    chk(key_o == '0 && !ctx_err_o && !key_valid_o && key_mask_o == 32'h0000_ffff,
        "R3 reset state", {key_o[254:0], ctx_err_o}, 256'h0);

    // full 32-byte key
    wr(3'd1, 64'd32);
    wr(3'd4, 64'h0011223344556677);
    wr(3'd5, 64'h8899aabbccddeeff);
    wr(3'd6, 64'h0123456789abcdef);
    chk(!key_valid_o, "R7 valid before last word", 256'(key_valid_o), 256'd0);
    wr(3'd7, 64'hfedcba9876543210);
    chk(key_valid_o, "R7 valid after last word", 256'(key_valid_o), 256'd1);
    chk(key_o[63:0] == 64'h0011223344556677, "R1 word0 low bytes",
        256'(key_o[63:0]), 256'h0011223344556677);

    // shrink to 24: word3 masked, further writes ignored
    wr(3'd1, 64'd24);
    wr(3'd7, 64'h5555555555555555);
    chk(key_o[255:192] == '0 && key_mask_o == 32'h00ff_ffff, "R2 bytes beyond 24 hidden",
        256'(key_o[255:192]), 256'd0);

    // busy write dropped, sticky error
    busy_i = 1;
    wr(3'd4, 64'hdeaddeaddeaddead);
    busy_i = 0;
    chk(ctx_err_o && key_o[63:0] == 64'h0011223344556677, "R4 busy write",
        256'(key_o[63:0]), 256'h0011223344556677);
    wr(3'd2, 64'd0);
    chk(ctx_err_o, "R6 zero write keeps error", 256'(ctx_err_o), 256'd1);
    wr(3'd2, 64'd1);
    chk(!ctx_err_o, "R6 one clears error", 256'(ctx_err_o), 256'd0);

    // illegal size
    wr(3'd1, 64'd20);
    rd(3'd1);
    chk(rd_data_o == 64'd16 && ctx_err_o, "R5 illegal size", 256'(rd_data_o), 256'd16);
    wr(3'd2, 64'd1);

    // read-back gated by decrypt bit; restore output
    rd(3'd4);
    chk(rd_data_o == 64'd0, "R8 read without decrypt", 256'(rd_data_o), 256'd0);
    wr(3'd0, 64'd2);
    rd(3'd5);
    chk(rd_data_o == 64'h8899aabbccddeeff, "R8 read with decrypt",
        256'(rd_data_o), 256'h8899aabbccddeeff);
    chk(!restore_key_o, "R9 no restore bit", 256'(restore_key_o), 256'd0);
    wr(3'd0, 64'd3);
    chk(restore_key_o, "R9 restore asserted", 256'(restore_key_o), 256'd1);

    // same-cycle read and write of mode: read sees old value
    rd_en_i = 1; rd_addr_i = 3'd0;
    wr(3'd0, 64'd0);
    chk(rd_data_o == 64'd3, "R8 read before write", 256'(rd_data_o), 256'd3);

    // reinit together with key write
    reinit_i = 1;
    wr(3'd4, 64'h1111111111111111);
    chk(key_o == '0 && !key_valid_o && !ctx_err_o, "R3 reinit wins", key_o, 256'd0);
    reinit_i = 1;
    wr(3'd1, 64'd7);
    chk(!ctx_err_o, "R3 reinit wins over bad size", 256'(ctx_err_o), 256'd0);

    // randomized mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      busy_i    = (r[3:0] == 4'd0);
      reinit_i  = (r[9:4] == 6'd0);
      wr_en_i   = r[10];
      wr_addr_i = r[13:11];
      rd_en_i   = r[14];
      rd_addr_i = r[17:15];
      case (r[19:18])
        2'd0:    wr_data_i = 64'(16 + 8 * (r[21:20] % 3));
        2'd1:    wr_data_i = 64'(r[25:20]);
        default: wr_data_i = {$urandom, $urandom};
      endcase
      cycle();
    end
    busy_i = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule